// File: doc/BRIEF.md
# Flash Completion Status Poller

This block runs on the host side of a parallel flash. After the host has issued a program or erase command, it starts the poller with the status address, the data it expects, a method and a poll budget. The poller then reads the status word through a simple request/acknowledge read port, one read at a time, until it can decide whether the operation finished. It then reports the outcome: success, failure or timeout.

Two methods are offered. In data polling, the completion bit of the word read back must equal the same bit of the expected data. In toggle polling, the toggle bit of two reads in a row must stop changing. In both methods the device raises a time-limit flag when it gives up. The flag and the polled bit do not settle on the same read. For that reason, once the flag is seen the poller takes extra reads before it reports failure. For an erase, the caller must place the poll address inside a sector that is being erased.

The bit positions are parameters. By default the completion bit is 7, the toggle bit is 6 and the time-limit flag is 5.

Top module: `fpoll_status_poller`

## Requirements
- R1: After synchronous reset, busy_o, rd_req_o and done_o are 0 and result_o is 0.
- R2: When start_i is high while the block is idle, the next cycle shows busy_o=1, rd_req_o=1 and rd_addr_o equal to addr_i. A start_i while busy has no effect, and the read address stays unchanged.
- R3: At most one read is outstanding. rd_req_o stays high, with a stable rd_addr_o, until a cycle in which rd_ack_i is high; rd_data_i is taken in that cycle.
- R4: In data mode (mode_i=0), a read whose bit 7 equals bit 7 of expect_i ends the operation with success.
- R5: In data mode, a read whose bit 7 differs from the expected bit and whose bit 5 is 0 is inconclusive, and another read follows.
- R6: In data mode, a read whose bit 7 differs and whose bit 5 is 1 causes exactly one more read. That read gives success if its bit 7 matches, otherwise failure.
- R7: In toggle mode (mode_i=1), the first read only sets a reference and is inconclusive. Each later read gives success if its bit 6 equals bit 6 of the read before it. A read where bit 6 changed and bit 5 is 0 is inconclusive.
- R8: In toggle mode, a read where bit 6 changed and bit 5 is 1 causes exactly two more reads. The result is success if bit 6 is equal in those two reads, otherwise failure.
- R9: Every inconclusive read counts against max_polls_i. When the count reaches max_polls_i, the operation ends with timeout and no further read is requested.
- R10: On completion, done_o rises and result_o gives the outcome: 1 for success, 2 for failure, 3 for timeout. Both stay unchanged until the next accepted start, and busy_o is 0 while done_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin polling (taken only when idle) |
| mode_i | input | 1 | 0 = data polling, 1 = toggle polling |
| addr_i | input | AW | Status address to poll |
| expect_i | input | DW | Expected data for data polling |
| max_polls_i | input | CW | Budget of inconclusive reads |
| rd_req_o | output | 1 | Read request, held until acknowledged |
| rd_addr_o | output | AW | Read address |
| rd_ack_i | input | 1 | Read acknowledge, rd_data_i valid |
| rd_data_i | input | DW | Read data |
| busy_o | output | 1 | Polling in progress |
| done_o | output | 1 | Result valid, held until next start |
| result_o | output | 2 | 0 none, 1 success, 2 failure, 3 timeout |

## Verification
The hardest cases to reach are the time-limit paths. In these the flag appears on a read whose polled bit still looks unfinished, and the outcome depends only on the one or two reads that follow. The bench answers every read from a per-run script of status words, with a random acknowledge delay. Directed scripts place the flag on a chosen read and set the follow-up words to match or mismatch. Random scripts set the flag rarely, so flagged and unflagged runs are mixed with timeouts. A bench model of the requirements predicts both the result and the exact number of reads.

// File: rtl/fpoll_pkg.sv
package fpoll_pkg;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_MAIN   = 3'd1,
    PH_RECHK  = 3'd2,
    PH_CONF_A = 3'd3,
    PH_CONF_B = 3'd4
  } phase_t;

  typedef enum logic [2:0] {
    DEC_OK      = 3'd0,
    DEC_FAIL    = 3'd1,
    DEC_AGAIN   = 3'd2,
    DEC_RECHECK = 3'd3,
    DEC_CONFIRM = 3'd4,
    DEC_STEP    = 3'd5
  } decision_t;

  localparam logic [1:0] RES_NONE    = 2'd0;
  localparam logic [1:0] RES_OK      = 2'd1;
  localparam logic [1:0] RES_FAIL    = 2'd2;
  localparam logic [1:0] RES_TIMEOUT = 2'd3;

endpackage

// File: rtl/fpoll_eval.sv
module fpoll_eval
  import fpoll_pkg::*;
#(
  parameter int DW       = 8,
  parameter int BIT_DONE = 7,
  parameter int BIT_TGL  = 6,
  parameter int BIT_LIM  = 5
) (
  input  phase_t          phase_i,
  input  logic            mode_i,
  input  logic [DW-1:0]   data_i,
  input  logic            exp_bit_i,
  input  logic            ref_bit_i,
  input  logic            have_ref_i,
  output decision_t       dec_o
);

  logic match_done;
  logic same_tgl;
  logic limit_hit;

  assign match_done = (data_i[BIT_DONE] == exp_bit_i);
  assign same_tgl   = (data_i[BIT_TGL] == ref_bit_i);
  assign limit_hit  = data_i[BIT_LIM];

  always_comb begin
    dec_o = DEC_AGAIN;
    unique case (phase_i)
      PH_MAIN: begin
        if (!mode_i) begin
          if (match_done)     dec_o = DEC_OK;
          else if (limit_hit) dec_o = DEC_RECHECK;
          else                dec_o = DEC_AGAIN;
        end else begin
          if (!have_ref_i)    dec_o = DEC_AGAIN;
          else if (same_tgl)  dec_o = DEC_OK;
          else if (limit_hit) dec_o = DEC_CONFIRM;
          else                dec_o = DEC_AGAIN;
        end
      end
      PH_RECHK:  dec_o = match_done ? DEC_OK : DEC_FAIL;
      PH_CONF_A: dec_o = DEC_STEP;
      PH_CONF_B: dec_o = same_tgl ? DEC_OK : DEC_FAIL;
      default:   dec_o = DEC_AGAIN;
    endcase
  end

endmodule

// File: rtl/fpoll_budget.sv
module fpoll_budget #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr_i,
  input  logic          inc_i,
  input  logic [CW-1:0] limit_i,
  output logic          last_o
);

  localparam int XW = CW + 1;

  logic [CW-1:0] cnt_q;
  logic [XW-1:0] cnt_next;

  assign cnt_next = {1'b0, cnt_q} + XW'(1);
  assign last_o   = (cnt_next >= {1'b0, limit_i});

  always_ff @(posedge clk) begin
    if (rst || clr_i) cnt_q <= '0;
    else if (inc_i)   cnt_q <= cnt_next[CW-1:0];
  end

endmodule

// File: rtl/fpoll_status_poller.sv
module fpoll_status_poller
  import fpoll_pkg::*;
#(
  parameter int AW       = 20,
  parameter int DW       = 8,
  parameter int CW       = 16,
  parameter int BIT_DONE = 7,
  parameter int BIT_TGL  = 6,
  parameter int BIT_LIM  = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic          mode_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] expect_i,
  input  logic [CW-1:0] max_polls_i,
  output logic          rd_req_o,
  output logic [AW-1:0] rd_addr_o,
  input  logic          rd_ack_i,
  input  logic [DW-1:0] rd_data_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [1:0]    result_o
);

  phase_t        phase_q;
  logic          mode_q;
  logic          exp_bit_q;
  logic          ref_bit_q;
  logic          have_ref_q;
  logic [CW-1:0] limit_q;
  decision_t     dec;
  logic          take;
  logic          accept;
  logic          last_poll;

  assign take   = rd_req_o && rd_ack_i;
  assign accept = start_i && (phase_q == PH_IDLE);
  assign busy_o = (phase_q != PH_IDLE);

  fpoll_eval #(
    .DW(DW), .BIT_DONE(BIT_DONE), .BIT_TGL(BIT_TGL), .BIT_LIM(BIT_LIM)
  ) i_eval (
    .phase_i   (phase_q),
    .mode_i    (mode_q),
    .data_i    (rd_data_i),
    .exp_bit_i (exp_bit_q),
    .ref_bit_i (ref_bit_q),
    .have_ref_i(have_ref_q),
    .dec_o     (dec)
  );

  fpoll_budget #(.CW(CW)) i_budget (
    .clk    (clk),
    .rst    (rst),
    .clr_i  (accept),
    .inc_i  (take && (dec == DEC_AGAIN)),
    .limit_i(limit_q),
    .last_o (last_poll)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q    <= PH_IDLE;
      mode_q     <= 1'b0;
      exp_bit_q  <= 1'b0;
      ref_bit_q  <= 1'b0;
      have_ref_q <= 1'b0;
      limit_q    <= '0;
      rd_req_o   <= 1'b0;
      rd_addr_o  <= '0;
      done_o     <= 1'b0;
      result_o   <= RES_NONE;
    end else if (accept) begin
      phase_q    <= PH_MAIN;
      mode_q     <= mode_i;
      exp_bit_q  <= expect_i[BIT_DONE];
      have_ref_q <= 1'b0;
      limit_q    <= max_polls_i;
      rd_req_o   <= 1'b1;
      rd_addr_o  <= addr_i;
      done_o     <= 1'b0;
      result_o   <= RES_NONE;
    end else if (take) begin
      unique case (dec)
        DEC_OK: begin
          phase_q  <= PH_IDLE;
          rd_req_o <= 1'b0;
          done_o   <= 1'b1;
          result_o <= RES_OK;
        end
        DEC_FAIL: begin
          phase_q  <= PH_IDLE;
          rd_req_o <= 1'b0;
          done_o   <= 1'b1;
          result_o <= RES_FAIL;
        end
        DEC_RECHECK: phase_q <= PH_RECHK;
        DEC_CONFIRM: phase_q <= PH_CONF_A;
        DEC_STEP: begin
          ref_bit_q <= rd_data_i[BIT_TGL];
          phase_q   <= PH_CONF_B;
        end
        default: begin
          ref_bit_q  <= rd_data_i[BIT_TGL];
          have_ref_q <= 1'b1;
          if (last_poll) begin
            phase_q  <= PH_IDLE;
            rd_req_o <= 1'b0;
            done_o   <= 1'b1;
            result_o <= RES_TIMEOUT;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/fpoll_checker.sv
module fpoll_checker #(
  parameter int AW = 20
) (
  input logic          clk,
  input logic          rst,
  input logic          start_i,
  input logic          rd_req_o,
  input logic [AW-1:0] rd_addr_o,
  input logic          rd_ack_i,
  input logic          busy_o,
  input logic          done_o,
  input logic [1:0]    result_o
);

  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!busy_o && !rd_req_o && !done_o && result_o == 2'd0));

  assert_start_taken_R2: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_o) |=> (busy_o && rd_req_o && !done_o));

  assert_req_held_R3: assert property (@(posedge clk) disable iff (rst)
    (rd_req_o && !rd_ack_i) |=> (rd_req_o && $stable(rd_addr_o)));

  assert_req_in_busy_R3: assert property (@(posedge clk) disable iff (rst)
    rd_req_o |-> busy_o);

  assert_done_valid_R10: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (!busy_o && result_o != 2'd0));

  assert_result_kept_R10: assert property (@(posedge clk) disable iff (rst)
    (done_o && !start_i) |=> (done_o && $stable(result_o)));

endmodule

bind fpoll_status_poller fpoll_checker #(.AW(AW)) i_fpoll_checker (
  .clk      (clk),
  .rst      (rst),
  .start_i  (start_i),
  .rd_req_o (rd_req_o),
  .rd_addr_o(rd_addr_o),
  .rd_ack_i (rd_ack_i),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .result_o (result_o)
);

// File: tb/test_fpoll_status_poller.sv
module test_fpoll_status_poller;

  localparam int AW = 20;
  localparam int DW = 8;
  localparam int CW = 16;
  localparam int SN = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start_i = 1'b0;
  logic          mode_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [DW-1:0] expect_i = '0;
  logic [CW-1:0] max_polls_i = '0;
  logic          rd_req_o;
  logic [AW-1:0] rd_addr_o;
  logic          rd_ack_i = 1'b0;
  logic [DW-1:0] rd_data_i = '0;
  logic          busy_o;
  logic          done_o;
  logic [1:0]    result_o;

  int checks = 0;
  int errors = 0;
  logic [7:0] script [SN];
  int idx = 0;
  int reads = 0;
  int wait_cnt = 0;
  logic [AW-1:0] cur_addr = '0;
  int addr_bad = 0;

  always #5 clk = ~clk;

  fpoll_status_poller #(.AW(AW), .DW(DW), .CW(CW)) i_fpoll_status_poller (
    .clk(clk), .rst(rst), .start_i(start_i), .mode_i(mode_i), .addr_i(addr_i),
    .expect_i(expect_i), .max_polls_i(max_polls_i), .rd_req_o(rd_req_o),
    .rd_addr_o(rd_addr_o), .rd_ack_i(rd_ack_i), .rd_data_i(rd_data_i),
    .busy_o(busy_o), .done_o(done_o), .result_o(result_o)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] sget(input int k);
    return (k < SN) ? script[k] : 8'h00;
  endfunction

  // Reference outcome from the requirements: returns result code, read count
  function automatic void model(input logic m, input logic [7:0] e, input int mx,
                                output int res, output int nrd);
    int k = 0;
    int cnt = 0;
    bit have = 0;
    logic rb = 0;
    logic [7:0] d, a, b;
    res = 0;
    for (int it = 0; it < 64; it++) begin
      d = sget(k); k++;
      if (!m) begin
        if (d[7] == e[7]) begin res = 1; break; end
        if (d[5]) begin
          a = sget(k); k++;
          res = (a[7] == e[7]) ? 1 : 2; break;
        end
      end else begin
        if (have && d[6] == rb) begin res = 1; break; end
        if (have && d[5]) begin
          a = sget(k); b = sget(k + 1); k += 2;
          res = (a[6] == b[6]) ? 1 : 2; break;
        end
        rb = d[6]; have = 1;
      end
      cnt++;
      if (cnt >= mx) begin res = 3; break; end
    end
    nrd = k;
  endfunction

  // Flash side responder
  initial begin
    forever begin
      @(negedge clk);
      if (rd_ack_i) begin
        rd_ack_i = 1'b0;
        wait_cnt = $urandom % 3;
      end else if (rd_req_o) begin
        if (wait_cnt == 0) begin
          if (rd_addr_o != cur_addr) addr_bad++;
          rd_data_i = sget(idx);
          idx++;
          reads++;
          rd_ack_i = 1'b1;
        end else begin
          wait_cnt--;
        end
      end
    end
  end

  task automatic run_case(input logic m, input logic [7:0] e, input int mx,
                          input logic [AW-1:0] a, input bit poke, input string tag);
    int eres, erd, n;
    model(m, e, mx, eres, erd);
    @(negedge clk);
    idx = 0; reads = 0; addr_bad = 0; cur_addr = a;
    start_i = 1'b1; mode_i = m; expect_i = e; max_polls_i = CW'(mx); addr_i = a;
    @(negedge clk);
    start_i = 1'b0;
    check(busy_o === 1'b1 && done_o === 1'b0, "R2 busy after start", int'(busy_o), 1);
    check(rd_addr_o === a, "R2 read address", int'(rd_addr_o), int'(a));
    if (poke) begin
      start_i = 1'b1; addr_i = ~a; mode_i = ~m;
      @(negedge clk);
      start_i = 1'b0;
      check(rd_addr_o === a, "R2 start while busy ignored", int'(rd_addr_o), int'(a));
    end
    n = 0;
    while (!done_o && n < 1000) begin @(negedge clk); n++; end
    check(done_o === 1'b1, {tag, " done"}, int'(done_o), 1);
    check(result_o === 2'(eres), {tag, " result"}, int'(result_o), eres);
    check(reads == erd, {tag, " read count"}, reads, erd);
    check(addr_bad == 0, "R3 address stable per read", addr_bad, 0);
    repeat (3) @(negedge clk);
    check(done_o === 1'b1 && result_o === 2'(eres) && rd_req_o === 1'b0,
          "R10 result held", int'(result_o), eres);
    check(reads == erd, "R9 no read after completion", reads, erd);
  endtask

  task automatic load(input logic [7:0] v0, input logic [7:0] v1,
                      input logic [7:0] v2, input logic [7:0] v3, input logic [7:0] fill);
    for (int i = 0; i < SN; i++) script[i] = fill;
    script[0] = v0; script[1] = v1; script[2] = v2; script[3] = v3;
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 150000) begin @(posedge clk); cyc++; end
    checks++; errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'd4711));
    for (int i = 0; i < SN; i++) script[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!busy_o && !rd_req_o && !done_o && result_o == 2'd0, "R1 reset state",
          int'(result_o), 0);

    load(8'h80, 8'h00, 8'h00, 8'h00, 8'h00);
    run_case(1'b0, 8'h80, 8, 20'h12345, 1'b1, "R4 first read match");
    load(8'h00, 8'h00, 8'h80, 8'h00, 8'h00);
    run_case(1'b0, 8'h80, 8, 20'h00100, 1'b0, "R5 match after polls");
    load(8'h80, 8'h00, 8'h00, 8'h00, 8'h00);
    run_case(1'b0, 8'h00, 8, 20'h00200, 1'b0, "R5 expected zero");
    load(8'h20, 8'h80, 8'h00, 8'h00, 8'h00);
    run_case(1'b0, 8'h80, 8, 20'h00300, 1'b0, "R6 recheck success");
    load(8'h20, 8'h20, 8'h80, 8'h00, 8'h00);
    run_case(1'b0, 8'h80, 8, 20'h00400, 1'b0, "R6 recheck failure");
    load(8'h40, 8'h40, 8'h00, 8'h00, 8'h00);
    run_case(1'b1, 8'h00, 8, 20'h00500, 1'b1, "R7 toggle stopped");
    load(8'h00, 8'h40, 8'h40, 8'h00, 8'h00);
    run_case(1'b1, 8'h00, 8, 20'h00600, 1'b0, "R7 toggle then stop");
    load(8'h20, 8'h20, 8'h00, 8'h00, 8'h00);
    run_case(1'b1, 8'h00, 8, 20'h00650, 1'b0, "R7 flag on reference read");
    load(8'h00, 8'h60, 8'h40, 8'h40, 8'h00);
    run_case(1'b1, 8'h00, 8, 20'h00700, 1'b0, "R8 confirm success");
    load(8'h00, 8'h60, 8'h00, 8'h40, 8'h00);
    run_case(1'b1, 8'h00, 8, 20'h00800, 1'b0, "R8 confirm failure");
    load(8'h00, 8'h00, 8'h00, 8'h00, 8'h00);
    run_case(1'b0, 8'h80, 4, 20'h00900, 1'b0, "R9 data timeout");
    for (int i = 0; i < SN; i++) script[i] = (i % 2) ? 8'h40 : 8'h00;
    run_case(1'b1, 8'h00, 3, 20'h00a00, 1'b0, "R9 toggle timeout");
    load(8'h00, 8'h80, 8'h00, 8'h00, 8'h00);
    run_case(1'b0, 8'h80, 1, 20'h00b00, 1'b0, "R9 budget of one");

    for (int r = 0; r < 60; r++) begin
      for (int i = 0; i < SN; i++) begin
        v = 8'($urandom);
        v[5] = (($urandom % 5) == 0);
        if (r % 2 == 0) v[7] = (($urandom % 4) == 0);
        script[i] = v;
      end
      run_case(1'($urandom), 8'($urandom), 1 + ($urandom % 6),
               AW'($urandom), (($urandom % 4) == 0), "R10 random run");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule